// File: doc/BRIEF.md
# Converter Sleep Wake-up Sequencer

This block sits on the host side of a converter and brings it back from a low-power state. A sleep wake request drives the converter's chip select low. The block then waits out a setup interval and sends one serial register write that puts the converter back in normal mode. After that it releases chip select and waits out the power-up interval before it raises `ready_o`. When chip select was already held low through the sleep period, the setup wait is skipped and the write starts at once. The power-up wait still applies in that case.

A nap wake request takes a shorter path with no serial traffic. The block waits the nap recovery interval, and adds a lock allowance for the converter's internal delay-locked loop when the host reports that the sampling clock was stopped. Every interval is a parameter counted in system clock cycles. The serial clock runs at a parameterised fraction of the system clock.

Top module: `wake_seq`

## Requirements
- R1: While reset is held and after it is released, `spi_csn_o` is 1, `spi_sclk_o` is 0, and both `busy_o` and `ready_o` are 0.
- R2: A sleep wake request taken while idle with `cs_low_in_sleep_i`=0 drives `spi_csn_o` low in the next cycle. The first rising edge of `spi_sclk_o` comes `SETUP_CYC+HALF_CYC+1` cycles after chip select falls.
- R3: With `cs_low_in_sleep_i`=1 the setup wait is skipped. The first rising edge of `spi_sclk_o` comes `HALF_CYC+1` cycles after chip select falls.
- R4: The write is serial mode 0 and sends exactly 16 bits, MSB first. `spi_sclk_o` idles low and `spi_mosi_o` is stable while `spi_sclk_o` is high. Bit 15 is the direction bit, 0 for a write. Bits 14..8 hold the register address 25 (7'b0011001). Bits 7..0 hold the data byte 8'h02, so the low nibble is 0010. The complete frame is 16'h1902.
- R5: `spi_csn_o` returns high on the same cycle as the 16th falling edge of `spi_sclk_o`, `32*HALF_CYC` cycles after the first bit starts.
- R6: `ready_o` rises `POWERUP_CYC` cycles after chip select returns high. It stays high until the next request is accepted, and it is 0 in the cycle after that request.
- R7: A nap wake request with `clk_stopped_i`=0 raises `ready_o` `NAP_CYC` cycles after the request edge. `spi_csn_o` stays high and `spi_sclk_o` stays low for the whole wait.
- R8: A nap wake request with `clk_stopped_i`=1 raises `ready_o` `NAP_CYC+DLL_CYC` cycles after the request edge.
- R9: `busy_o` is 1 from the cycle after an accepted request until the cycle in which `ready_o` rises. `busy_o` and `ready_o` are never 1 together. Requests that arrive while busy are ignored and leave every timing unchanged.
- R10: When a sleep request and a nap request arrive in the same cycle, the sleep wake sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_req_i | input | 1 | Request to wake from sleep |
| nap_req_i | input | 1 | Request to wake from nap |
| cs_low_in_sleep_i | input | 1 | Chip select was held low during sleep |
| clk_stopped_i | input | 1 | Sampling clock was stopped during nap |
| spi_csn_o | output | 1 | Converter chip select, active low |
| spi_sclk_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Converter recovered to normal operation |

## Verification
The situation hardest to bring about from the ports is a request that lands in the middle of a running sequence. The block gives no sign that it dropped such a request except that its timing stays unchanged. The bench therefore injects a nap request during the setup wait of a sleep wake and asserts both requests in one cycle. It then checks that the chip select edges, the bit stream and the ready cycle match the sleep-only expectation exactly. It also checks that no nap recovery follows once `ready_o` is up. Each path is measured in cycles from the request edge against counts that the bench derives from its own copies of the interval parameters.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XSTART,
    ST_XFER,
    ST_POWER,
    ST_NAP
  } seq_state_e;

  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [ADDR_W-1:0] addr,
                                                     input logic [DATA_W-1:0] data);
    return {1'b0, addr, data};
  endfunction
endpackage

// File: rtl/wake_delay.sv
module wake_delay #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // loaded value N gives N cycles in the waiting state
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wake_spi_tx.sv
module wake_spi_tx #(
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned HALF_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               done_o
);
  localparam int unsigned HW = $clog2(HALF_CYC + 1);
  localparam int unsigned BW = $clog2(FRAME_W + 1);

  logic               active_q;
  logic               sclk_q;
  logic [FRAME_W-1:0] sh_q;
  logic [HW-1:0]      hcnt_q;
  logic [BW-1:0]      bits_q;
  logic               tick;
  logic               last_bit;

  assign tick     = (hcnt_q == HW'(1));
  assign last_bit = (bits_q == BW'(FRAME_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      sh_q     <= '0;
      hcnt_q   <= '0;
      bits_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      sh_q     <= frame_i;
      hcnt_q   <= HW'(HALF_CYC);
      bits_q   <= '0;
    end else if (active_q) begin
      if (tick) begin
        hcnt_q <= HW'(HALF_CYC);
        sclk_q <= ~sclk_q;
        if (sclk_q) begin
          sh_q   <= sh_q << 1;
          bits_q <= bits_q + 1'b1;
          if (last_bit) active_q <= 1'b0;
        end
      end else begin
        hcnt_q <= hcnt_q - 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = active_q & sh_q[FRAME_W-1];
  assign done_o = active_q & tick & sclk_q & last_bit;
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 16,
  parameter int unsigned POWERUP_CYC = 64,
  parameter int unsigned NAP_CYC     = 8,
  parameter int unsigned DLL_CYC     = 32,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_req_i,
  input  logic             nap_req_i,
  input  logic             cs_low_i,
  input  logic             clk_stopped_i,
  input  logic             dly_done_i,
  input  logic             tx_done_i,
  output logic             dly_load_o,
  output logic [CNT_W-1:0] dly_val_o,
  output logic             tx_start_o,
  output logic             csn_o,
  output logic             busy_o,
  output logic             ready_o
);
  seq_state_e st_q, st_d;
  logic       csn_q, csn_d;
  logic       rdy_q, rdy_d;

  always_comb begin
    st_d       = st_q;
    csn_d      = csn_q;
    rdy_d      = rdy_q;
    dly_load_o = 1'b0;
    dly_val_o  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (wake_req_i) begin
          rdy_d = 1'b0;
          csn_d = 1'b0;
          if (cs_low_i) begin
            st_d = ST_XSTART;
          end else begin
            st_d       = ST_SETUP;
            dly_load_o = 1'b1;
            dly_val_o  = CNT_W'(SETUP_CYC);
          end
        end else if (nap_req_i) begin
          rdy_d      = 1'b0;
          st_d       = ST_NAP;
          dly_load_o = 1'b1;
          dly_val_o  = clk_stopped_i ? CNT_W'(NAP_CYC + DLL_CYC) : CNT_W'(NAP_CYC);
        end
      end
      ST_SETUP:  if (dly_done_i) st_d = ST_XSTART;
      ST_XSTART: st_d = ST_XFER;
      ST_XFER: begin
        if (tx_done_i) begin
          csn_d      = 1'b1;
          st_d       = ST_POWER;
          dly_load_o = 1'b1;
          dly_val_o  = CNT_W'(POWERUP_CYC);
        end
      end
      ST_POWER, ST_NAP: begin
        if (dly_done_i) begin
          st_d  = ST_IDLE;
          rdy_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      csn_q <= 1'b1;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      csn_q <= csn_d;
      rdy_q <= rdy_d;
    end
  end

  assign tx_start_o = (st_q == ST_XSTART);
  assign csn_o      = csn_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign ready_o    = rdy_q;
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 15000,
  parameter int unsigned POWERUP_CYC = 100000,
  parameter int unsigned NAP_CYC     = 100,
  parameter int unsigned DLL_CYC     = 5200,
  parameter int unsigned HALF_CYC    = 4,
  parameter int unsigned WAKE_ADDR   = 25,
  parameter int unsigned WAKE_DATA   = 8'h02
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_req_i,
  input  logic nap_req_i,
  input  logic cs_low_in_sleep_i,
  input  logic clk_stopped_i,
  output logic spi_csn_o,
  output logic spi_sclk_o,
  output logic spi_mosi_o,
  output logic busy_o,
  output logic ready_o
);
  localparam int unsigned MAX_A   = (SETUP_CYC > POWERUP_CYC) ? SETUP_CYC : POWERUP_CYC;
  localparam int unsigned MAX_NAP = NAP_CYC + DLL_CYC;
  localparam int unsigned MAX_ALL = (MAX_A > MAX_NAP) ? MAX_A : MAX_NAP;
  localparam int unsigned CNT_W   = $clog2(MAX_ALL + 1);

  localparam logic [FRAME_W-1:0] FRAME =
    build_frame(ADDR_W'(WAKE_ADDR), DATA_W'(WAKE_DATA));

  logic             dly_load;
  logic [CNT_W-1:0] dly_val;
  logic             dly_done;
  logic             tx_start;
  logic             tx_done;

  wake_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .POWERUP_CYC(POWERUP_CYC),
    .NAP_CYC    (NAP_CYC),
    .DLL_CYC    (DLL_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wake_req_i   (wake_req_i),
    .nap_req_i    (nap_req_i),
    .cs_low_i     (cs_low_in_sleep_i),
    .clk_stopped_i(clk_stopped_i),
    .dly_done_i   (dly_done),
    .tx_done_i    (tx_done),
    .dly_load_o   (dly_load),
    .dly_val_o    (dly_val),
    .tx_start_o   (tx_start),
    .csn_o        (spi_csn_o),
    .busy_o       (busy_o),
    .ready_o      (ready_o)
  );

  wake_delay #(.CNT_W(CNT_W)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (dly_load),
    .load_val_i(dly_val),
    .done_o    (dly_done)
  );

  wake_spi_tx #(.FRAME_W(FRAME_W), .HALF_CYC(HALF_CYC)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .frame_i(FRAME),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .done_o (tx_done)
  );
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wake_req_i,
  input logic nap_req_i,
  input logic spi_csn_o,
  input logic spi_sclk_o,
  input logic spi_mosi_o,
  input logic busy_o,
  input logic ready_o
);
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (spi_csn_o && !spi_sclk_o));

  p_sclk_under_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !spi_csn_o);

  p_mosi_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));

  p_csn_on_last_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_csn_o) |-> $fell(spi_sclk_o));

  p_ready_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !wake_req_i && !nap_req_i) |=> ready_o);

  p_ready_busy_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && busy_o));
endmodule

bind wake_seq wake_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wake_req_i(wake_req_i),
  .nap_req_i (nap_req_i),
  .spi_csn_o (spi_csn_o),
  .spi_sclk_o(spi_sclk_o),
  .spi_mosi_o(spi_mosi_o),
  .busy_o    (busy_o),
  .ready_o   (ready_o)
);

// File: tb/sim_wake_seq.sv
module sim_wake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP  = 5;
  localparam int POWER  = 9;
  localparam int NAP    = 3;
  localparam int DLL    = 6;
  localparam int HALF   = 2;
  localparam logic [15:0] EXP_FRAME = {1'b0, 7'd25, 8'h02};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0, nap = 1'b0, csl = 1'b0, stopped = 1'b0;
  logic csn, sclk, mosi, busy, ready;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wake_seq #(
    .SETUP_CYC(SETUP), .POWERUP_CYC(POWER), .NAP_CYC(NAP),
    .DLL_CYC(DLL), .HALF_CYC(HALF), .WAKE_ADDR(25), .WAKE_DATA(8'h02)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wake_req_i(wake), .nap_req_i(nap),
    .cs_low_in_sleep_i(csl), .clk_stopped_i(stopped),
    .spi_csn_o(csn), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
    .busy_o(busy), .ready_o(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sleep wake; poke injects a nap request while busy, both raises nap with wake
  task automatic run_sleep(input bit cs_low, input bit poke, input bit both, input string tag);
    int s = cs_low ? 0 : SETUP;
    int rise_k = -1, csn_rise_k = -1, ready_k = -1, nbits = 0, busy_gap = 0;
    logic [15:0] frame = '0;
    logic prev_sclk = 1'b0;
    @(negedge clk);
    csl = cs_low; wake = 1'b1; nap = both;
    @(negedge clk);
    wake = 1'b0; nap = 1'b0;
    check({tag, " R2 csn low k1"}, int'(csn), 0);
    check({tag, " R6 ready cleared"}, int'(ready), 0);
    check({tag, " R9 busy k1"}, int'(busy), 1);
    for (int k = 1; k < 400 && ready_k < 0; k++) begin
      if (k > 1) begin
        if (poke && k == 3) nap = 1'b1;
        if (k == 4) nap = 1'b0;
        @(negedge clk);
      end
      if (sclk && !prev_sclk) begin
        if (rise_k < 0) rise_k = k;
        frame = {frame[14:0], mosi};
        nbits++;
      end
      prev_sclk = sclk;
      if (k > 1 && csn && csn_rise_k < 0) csn_rise_k = k;
      if (ready) ready_k = k;
      else if (!busy) busy_gap++;
    end
    check({tag, cs_low ? " R3 first sclk rise" : " R2 first sclk rise"}, rise_k, s + 2 + HALF);
    check({tag, " R4 bit count"}, nbits, 16);
    check({tag, " R4 frame"}, int'(frame), int'(EXP_FRAME));
    check({tag, " R5 csn rise"}, csn_rise_k, s + 2 + 32*HALF);
    check({tag, " R6 ready"}, ready_k, s + 2 + 32*HALF + POWER);
    check({tag, " R9 busy continuous"}, busy_gap, 0);
    check({tag, " R9 busy low at ready"}, int'(busy), 0);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (!ready || busy || !csn || sclk) begin
        check({tag, " R6 R9 quiet after ready"}, {ready, busy, csn, sclk}, 4'b1010);
        break;
      end
    end
  endtask

  task automatic run_nap(input bit stop, input string tag);
    int w = stop ? NAP + DLL : NAP;
    int ready_k = -1, spi_act = 0;
    @(negedge clk);
    stopped = stop; nap = 1'b1;
    @(negedge clk);
    nap = 1'b0;
    check({tag, " R9 busy k1"}, int'(busy), 1);
    check({tag, " R6 ready cleared"}, int'(ready), 0);
    for (int k = 1; k < 200 && ready_k < 0; k++) begin
      if (k > 1) @(negedge clk);
      if (!csn || sclk) spi_act++;
      if (ready) ready_k = k;
    end
    check({tag, stop ? " R8 ready" : " R7 ready"}, ready_k, w + 1);
    check({tag, " R7 no spi activity"}, spi_act, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    check("R1 csn reset", int'(csn), 1);
    check("R1 sclk reset", int'(sclk), 0);
    check("R1 busy reset", int'(busy), 0);
    check("R1 ready reset", int'(ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after release", {csn, sclk, busy, ready}, 4'b1000);
    run_sleep(1'b0, 1'b0, 1'b0, "sleep_cs_high");
    run_sleep(1'b1, 1'b0, 1'b0, "sleep_cs_low");
    run_nap(1'b0, "nap_running");
    run_nap(1'b1, "nap_stopped");
    run_sleep(1'b0, 1'b1, 1'b0, "sleep_poke R9");
    run_sleep(1'b1, 1'b1, 1'b0, "sleep_low_poke R9");
    run_sleep(1'b0, 1'b0, 1'b1, "both R10");
    run_sleep(1'b1, 1'b0, 1'b1, "both_low R10");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule